// File: doc/BRIEF.md
# MMU Fault Status Recorder

This block keeps the record of the most recent address-translation fault for two translation paths: one for instruction fetches and one for data accesses. When the fault-detection logic elsewhere raises a report strobe, the block packs the access's write flag, context class, side-effect attribute, fault code and 8-bit address space identifier into a fixed-layout status word. The data path also captures the faulting virtual address in a separate register on the same clock edge.

The low two bits of each status word flag the record as valid and mark an overflow. A fault that arrives while the previous record is still marked valid sets both bits, so a trap handler can tell that at least one report was lost. Software reads the three registers through a small address-selected port and writes them through the same port, typically writing zero to clear the valid bit and rearm overflow detection. Detecting faults is the job of other logic. This block only records them.

Top module: `mmu_fault_recorder`

## Requirements
- R1: While rst_ni is low, both status words and the data fault address read as zero.
- R2: A fault strobe on a side whose status bit 0 is clear loads that status word with bits [1:0] = 2'b01. Every other bit comes only from the new report, and nothing survives from the previous contents.
- R3: A fault strobe on a side whose status bit 0 is set loads bits [1:0] = 2'b11. The remaining fields are taken from the new report.
- R4: Status word layout: bit 2 holds the write flag, bits [5:4] the context class (0 primary, 1 secondary, 2 nucleus), bit 6 the side-effect flag, bits [13:7] the fault code (zero-extended to nine bits, so bits 14 and 15 stay zero for FT_W=7), and bits [23:16] the address space identifier. Bit 3 is zero after a fault.
- R5: A data-side fault strobe loads df_va_i into the data fault address register on the same edge. An instruction-side fault leaves that register unchanged.
- R6: A software write replaces the whole selected register. Select codes on sw_addr_i: 0 is the instruction status, 1 the data status and 2 the data fault address. Status registers take the low 24 bits of sw_wdata_i. Writing a status word with bit 0 clear makes the next fault on that side report 2'b01.
- R7: When a fault strobe and a software write hit the same register in one cycle, the fault wins. Overflow is judged on the register contents before that edge.
- R8: sw_rdata_o returns the register selected by sw_addr_i, zero-extended, in the same cycle. Select code 3 reads zero, and writes to it change nothing.
- R9: A fault or a software write to one side leaves the other side's status word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| if_valid_i | input | 1 | Instruction-side fault report strobe |
| if_write_i | input | 1 | Instruction-side write flag |
| if_ctx_i | input | 2 | Instruction-side context class |
| if_se_i | input | 1 | Instruction-side side-effect flag |
| if_type_i | input | FT_W | Instruction-side fault code |
| if_asi_i | input | 8 | Instruction-side address space identifier |
| df_valid_i | input | 1 | Data-side fault report strobe |
| df_write_i | input | 1 | Data-side write flag |
| df_ctx_i | input | 2 | Data-side context class |
| df_se_i | input | 1 | Data-side side-effect flag |
| df_type_i | input | FT_W | Data-side fault code |
| df_asi_i | input | 8 | Data-side address space identifier |
| df_va_i | input | VA_W | Data-side faulting virtual address |
| sw_we_i | input | 1 | Software write enable |
| sw_addr_i | input | 2 | Software register select |
| sw_wdata_i | input | VA_W | Software write data |
| sw_rdata_o | output | VA_W | Software read data |
| i_status_o | output | 24 | Instruction-side status word |
| d_status_o | output | 24 | Data-side status word |
| d_addr_o | output | VA_W | Data fault address |

## Verification
A fault report and a software write can land on the same register in the same cycle, which matters most when software clears the valid bit just as a new fault arrives. The bench provokes this on both status words and on the address register. It writes zero over a valid record while a strobe is raised, and it writes all ones over a cleared record. It then judges the result by whether the word carries the report's fields with the overflow bits derived from the contents before the edge (2'b11 in the first case, 2'b01 in the second), and never the written value.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int ASI_W     = 8;
  localparam int CTX_W     = 2;
  localparam int BIT_VALID = 0;
  localparam int BIT_OVF   = 1;
  localparam int BIT_WR    = 2;
  localparam int CTX_LSB   = 4;
  localparam int BIT_SE    = 6;
  localparam int FT_LSB    = 7;
  localparam int ASI_LSB   = 16;
  localparam int FT_MAX_W  = ASI_LSB - FT_LSB;
  localparam int STATUS_W  = ASI_LSB + ASI_W;

  typedef enum logic [CTX_W-1:0] {
    CTX_PRIMARY   = 2'd0,
    CTX_SECONDARY = 2'd1,
    CTX_NUCLEUS   = 2'd2
  } ctx_e;

  typedef enum logic [1:0] {
    SW_ISTAT = 2'd0,
    SW_DSTAT = 2'd1,
    SW_DADDR = 2'd2,
    SW_NONE  = 2'd3
  } sw_sel_e;

  typedef struct packed {
    logic                write;
    ctx_e                ctx;
    logic                side_eff;
    logic [FT_MAX_W-1:0] ftype;
    logic [ASI_W-1:0]    asi;
  } fault_rec_t;
endpackage

// File: rtl/fsr_compose.sv
module fsr_compose
  import fsr_pkg::*;
(
  input  fault_rec_t          rec_i,
  input  logic                prev_valid_i,
  output logic [STATUS_W-1:0] word_o
);
  // fresh word each time; only the overflow bit looks at the old contents
  always_comb begin
    word_o                      = '0;
    word_o[BIT_VALID]           = 1'b1;
    word_o[BIT_OVF]             = prev_valid_i;
    word_o[BIT_WR]              = rec_i.write;
    word_o[CTX_LSB +: CTX_W]    = rec_i.ctx;
    word_o[BIT_SE]              = rec_i.side_eff;
    word_o[FT_LSB +: FT_MAX_W]  = rec_i.ftype;
    word_o[ASI_LSB +: ASI_W]    = rec_i.asi;
  end
endmodule

// File: rtl/fsr_side.sv
module fsr_side
  import fsr_pkg::*;
#(
  parameter bit HAS_VA = 1'b1,
  parameter int VA_W   = 48
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flt_i,
  input  fault_rec_t          rec_i,
  input  logic [VA_W-1:0]     va_i,
  input  logic                st_we_i,
  input  logic                va_we_i,
  input  logic [VA_W-1:0]     wdata_i,
  output logic [STATUS_W-1:0] status_o,
  output logic [VA_W-1:0]     va_o
);
  logic [STATUS_W-1:0] status_q;
  logic [STATUS_W-1:0] new_word;

  fsr_compose u_compose (
    .rec_i        (rec_i),
    .prev_valid_i (status_q[BIT_VALID]),
    .word_o       (new_word)
  );

  // fault report outranks a software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      status_q <= '0;
    else if (flt_i)   status_q <= new_word;
    else if (st_we_i) status_q <= wdata_i[STATUS_W-1:0];
  end

  assign status_o = status_q;

  if (HAS_VA) begin : g_va
    logic [VA_W-1:0] va_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      va_q <= '0;
      else if (flt_i)   va_q <= va_i;
      else if (va_we_i) va_q <= wdata_i;
    end
    assign va_o = va_q;
  end else begin : g_no_va
    logic unused_va;
    assign unused_va = ^{va_i, va_we_i};
    assign va_o      = '0;
  end
endmodule

// File: rtl/mmu_fault_recorder.sv
module mmu_fault_recorder
  import fsr_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int FT_W = 7
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         if_valid_i,
  input  logic                         if_write_i,
  input  logic [1:0]                   if_ctx_i,
  input  logic                         if_se_i,
  input  logic [FT_W-1:0]              if_type_i,
  input  logic [7:0]                   if_asi_i,
  input  logic                         df_valid_i,
  input  logic                         df_write_i,
  input  logic [1:0]                   df_ctx_i,
  input  logic                         df_se_i,
  input  logic [FT_W-1:0]              df_type_i,
  input  logic [7:0]                   df_asi_i,
  input  logic [VA_W-1:0]              df_va_i,
  input  logic                         sw_we_i,
  input  logic [1:0]                   sw_addr_i,
  input  logic [VA_W-1:0]              sw_wdata_i,
  output logic [VA_W-1:0]              sw_rdata_o,
  output logic [fsr_pkg::STATUS_W-1:0] i_status_o,
  output logic [fsr_pkg::STATUS_W-1:0] d_status_o,
  output logic [VA_W-1:0]              d_addr_o
);
  fault_rec_t i_rec, d_rec;
  sw_sel_e    sel;
  logic [VA_W-1:0] i_va_unused;

  assign sel = sw_sel_e'(sw_addr_i);

  always_comb begin
    i_rec                   = '0;
    i_rec.write             = if_write_i;
    i_rec.ctx               = ctx_e'(if_ctx_i);
    i_rec.side_eff          = if_se_i;
    i_rec.ftype[FT_W-1:0]   = if_type_i;
    i_rec.asi               = if_asi_i;
    d_rec                   = '0;
    d_rec.write             = df_write_i;
    d_rec.ctx               = ctx_e'(df_ctx_i);
    d_rec.side_eff          = df_se_i;
    d_rec.ftype[FT_W-1:0]   = df_type_i;
    d_rec.asi               = df_asi_i;
  end

  fsr_side #(.HAS_VA(1'b0), .VA_W(VA_W)) u_iside (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flt_i    (if_valid_i),
    .rec_i    (i_rec),
    .va_i     ('0),
    .st_we_i  (sw_we_i && sel == SW_ISTAT),
    .va_we_i  (1'b0),
    .wdata_i  (sw_wdata_i),
    .status_o (i_status_o),
    .va_o     (i_va_unused)
  );

  fsr_side #(.HAS_VA(1'b1), .VA_W(VA_W)) u_dside (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flt_i    (df_valid_i),
    .rec_i    (d_rec),
    .va_i     (df_va_i),
    .st_we_i  (sw_we_i && sel == SW_DSTAT),
    .va_we_i  (sw_we_i && sel == SW_DADDR),
    .wdata_i  (sw_wdata_i),
    .status_o (d_status_o),
    .va_o     (d_addr_o)
  );

  always_comb begin
    sw_rdata_o = '0;
    unique case (sel)
      SW_ISTAT: sw_rdata_o[STATUS_W-1:0] = i_status_o;
      SW_DSTAT: sw_rdata_o[STATUS_W-1:0] = d_status_o;
      SW_DADDR: sw_rdata_o               = d_addr_o;
      default:  sw_rdata_o               = '0;
    endcase
  end
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
  parameter int VA_W = 48
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              if_valid_i,
  input logic              df_valid_i,
  input logic [7:0]        df_asi_i,
  input logic [VA_W-1:0]   df_va_i,
  input logic              sw_we_i,
  input logic [1:0]        sw_addr_i,
  input logic [VA_W-1:0]   sw_rdata_o,
  input logic [23:0]       i_status_o,
  input logic [23:0]       d_status_o,
  input logic [VA_W-1:0]   d_addr_o
);
  always @(posedge clk_i)
    if (!rst_ni) a_r1_reset_zero: assert (i_status_o == '0 && d_status_o == '0 && d_addr_o == '0);

  a_r2_first_i: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_valid_i && !i_status_o[0] |=> i_status_o[1:0] == 2'b01);
  a_r2_first_d: assert property (@(posedge clk_i) disable iff (!rst_ni)
    df_valid_i && !d_status_o[0] |=> d_status_o[1:0] == 2'b01);
  a_r3_ovf_i: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_valid_i && i_status_o[0] |=> i_status_o[1:0] == 2'b11);
  a_r3_ovf_d: assert property (@(posedge clk_i) disable iff (!rst_ni)
    df_valid_i && d_status_o[0] |=> d_status_o[1:0] == 2'b11);
  a_r4_asi_d: assert property (@(posedge clk_i) disable iff (!rst_ni)
    df_valid_i |=> d_status_o[23:16] == $past(df_asi_i) && !d_status_o[3]);
  a_r5_va_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    df_valid_i |=> d_addr_o == $past(df_va_i));
  a_r5_va_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !df_valid_i && !(sw_we_i && sw_addr_i == 2'd2) |=> $stable(d_addr_o));
  a_r7_fault_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_valid_i && sw_we_i && sw_addr_i == 2'd0 |=> i_status_o[0]);
  a_r8_none_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_addr_i == 2'd3 |-> sw_rdata_o == '0);
  a_r9_i_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !if_valid_i && !(sw_we_i && sw_addr_i == 2'd0) |=> $stable(i_status_o));
  a_r9_d_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !df_valid_i && !(sw_we_i && sw_addr_i == 2'd1) |=> $stable(d_status_o));
endmodule

bind mmu_fault_recorder fsr_checker #(.VA_W(VA_W)) u_fsr_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .if_valid_i (if_valid_i),
  .df_valid_i (df_valid_i),
  .df_asi_i   (df_asi_i),
  .df_va_i    (df_va_i),
  .sw_we_i    (sw_we_i),
  .sw_addr_i  (sw_addr_i),
  .sw_rdata_o (sw_rdata_o),
  .i_status_o (i_status_o),
  .d_status_o (d_status_o),
  .d_addr_o   (d_addr_o)
);

// File: tb/sim_mmu_fault_recorder.sv
module sim_mmu_fault_recorder;
  localparam int CLK_PERIOD = 10;
  localparam int VA_W = 48;
  localparam int FT_W = 7;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ifv = 0, iw = 0, is = 0;
  logic [1:0] ic = 0;
  logic [FT_W-1:0] it = 0;
  logic [7:0] ia = 0;
  logic dfv = 0, dw = 0, ds = 0;
  logic [1:0] dc = 0;
  logic [FT_W-1:0] dt = 0;
  logic [7:0] da = 0;
  logic [VA_W-1:0] dva = 0;
  logic swe = 0;
  logic [1:0] sa = 0;
  logic [VA_W-1:0] swd = 0;
  logic [VA_W-1:0] rdata, d_addr;
  logic [23:0] i_status, d_status;

  logic [23:0] mi = 0, md = 0;
  logic [VA_W-1:0] ma = 0;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_fault_recorder #(.VA_W(VA_W), .FT_W(FT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .if_valid_i(ifv), .if_write_i(iw), .if_ctx_i(ic), .if_se_i(is), .if_type_i(it), .if_asi_i(ia),
    .df_valid_i(dfv), .df_write_i(dw), .df_ctx_i(dc), .df_se_i(ds), .df_type_i(dt), .df_asi_i(da),
    .df_va_i(dva), .sw_we_i(swe), .sw_addr_i(sa), .sw_wdata_i(swd), .sw_rdata_o(rdata),
    .i_status_o(i_status), .d_status_o(d_status), .d_addr_o(d_addr)
  );

  function automatic logic [23:0] mk(logic prev0, logic wr, logic [1:0] ctx, logic se,
                                     logic [FT_W-1:0] ft, logic [7:0] asi);
    return (24'(asi) << 16) + (24'(ft) << 7) + (24'(se) << 6) + (24'(ctx) << 4)
         + (24'(wr) << 2) + (prev0 ? 24'd3 : 24'd1);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " istat"}, 64'(i_status), 64'(mi));
    chk({tag, " dstat"}, 64'(d_status), 64'(md));
    chk({tag, " daddr"}, 64'(d_addr), 64'(ma));
  endtask

  task automatic step(input string tag);
    @(posedge clk); #1;
    if (ifv) mi = mk(mi[0], iw, ic, is, it, ia);
    else if (swe && sa == 2'd0) mi = swd[23:0];
    if (dfv) begin
      md = mk(md[0], dw, dc, ds, dt, da);
      ma = dva;
    end else begin
      if (swe && sa == 2'd1) md = swd[23:0];
      if (swe && sa == 2'd2) ma = swd;
    end
    ifv = 0; dfv = 0; swe = 0;
    check_all(tag);
  endtask

  task automatic rd(input string tag, input logic [1:0] a, input logic [VA_W-1:0] exp);
    sa = a; #1;
    chk(tag, 64'(rdata), 64'(exp));
  endtask

  task automatic sw_write(input logic [1:0] a, input logic [VA_W-1:0] d);
    swe = 1; sa = a; swd = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + 1);
    check_all("R1 reset");
    rd("R1 read", 2'd2, '0);
    rst_ni = 1;
    @(posedge clk); #1;

    // R2 R3 R4 sweep: clear, first fault, overflowing second fault, on each side
    for (int side = 0; side < 2; side++)
      for (int c = 0; c < 3; c++)
        for (int w = 0; w < 2; w++)
          for (int s = 0; s < 2; s++)
            for (int f = 0; f < 4; f++)
              for (int a = 0; a < 3; a++) begin
                logic [FT_W-1:0] ftv;
                logic [7:0] asv;
                ftv = (f == 0) ? 7'h00 : (f == 1) ? 7'h01 : (f == 2) ? 7'h55 : 7'h7f;
                asv = (a == 0) ? 8'h00 : (a == 1) ? 8'ha5 : 8'hff;
                sw_write(side == 0 ? 2'd0 : 2'd1, '0);
                step("R6 clear");
                iw = w[0]; ic = c[1:0]; is = s[0]; it = ftv; ia = asv;
                dw = w[0]; dc = c[1:0]; ds = s[0]; dt = ftv; da = asv;
                dva = VA_W'(48'h1000_0000_0000 + 48'(side * 97 + c * 31 + f * 7 + a));
                if (side == 0) ifv = 1; else dfv = 1;
                step("R2 R4 first");
                ia = ~asv; da = ~asv; iw = ~w[0]; dw = ~w[0];
                if (side == 0) ifv = 1; else dfv = 1;
                step("R3 R4 overflow");
              end

    // R6 replace with arbitrary pattern, then fault observes written bit 0
    sw_write(2'd1, 48'h0000_005a_5a5a);
    step("R6 write dstat");
    rd("R6 R8 readback dstat", 2'd1, 48'h5a5a5a);
    dfv = 1; dc = 2'd2; dt = 7'h12; da = 8'h3c; dva = 48'hdead_beef_0008;
    step("R6 bit0 clear gives 01");
    sw_write(2'd0, 48'h0000_0000_0001);
    step("R6 write istat");
    ifv = 1; ic = 2'd1; it = 7'h2a; ia = 8'h81;
    step("R6 bit0 set gives 11");
    rd("R8 readback istat", 2'd0, 48'(mi));
    sw_write(2'd2, 48'h1234_5678_9abc);
    step("R6 write daddr");
    rd("R8 readback daddr", 2'd2, 48'h1234_5678_9abc);

    // R5 instruction fault leaves address; R9 other side untouched
    ifv = 1; ia = 8'h07;
    step("R5 R9 ifault only");
    dfv = 1; dva = 48'h0000_0000_fff8; da = 8'h44;
    step("R5 R9 dfault only");

    // R7 collisions
    ifv = 1; ia = 8'h10; sw_write(2'd0, '0);
    step("R7 istat fault over clear");
    sw_write(2'd0, '0);
    step("R7 prep");
    ifv = 1; ia = 8'h20; sw_write(2'd0, 48'hff_ffff);
    step("R7 istat fault over ones");
    dfv = 1; da = 8'h30; dva = 48'h0000_0000_0040; sw_write(2'd1, 48'hff_fffe);
    step("R7 dstat fault over write");
    dfv = 1; da = 8'h31; dva = 48'h0000_0000_0080; sw_write(2'd2, 48'h7777_7777_7777);
    step("R7 daddr fault over write");

    // R8 select 3 reads zero and ignores writes
    sw_write(2'd3, '1);
    step("R8 write to none");
    rd("R8 read none", 2'd3, '0);
    rd("R8 read dstat", 2'd1, 48'(md));

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule